// File: doc/BRIEF.md
# Inter-core event flag bank

This block carries single-bit event notifications from a producing core to a consuming core through a shared vector of 32 flags. The producer owns one register port. Through it, the producer raises flags by writing ones to a set register, withdraws flags by writing ones to a withdraw register, and reads back the whole vector at a third offset. The consumer owns a second register port. Through it, the consumer reads the same vector as a status word and retires events by writing ones to an acknowledge register. Flag number n is held in data bit n-1.

The four lowest flags also drive level interrupt lines toward the consumer. The remaining flags are polled only. Both ports run on one clock. Read data is registered and appears one cycle after the address is presented. The asynchronous active-low reset is released through a two-stage synchronizer.

Sender offsets are 0x0 set, 0x4 withdraw and 0x8 flag view. Receiver offsets are 0x0 status and 0x4 acknowledge. Any other offset is unmapped.

Top module: `ipc_flag_bank`

## Requirements
- R1: While rst_n is low, and until the second rising edge after it rises, every flag is 0, irq_o is 0, and s_rdata and r_rdata are 0. Writes take effect from the third rising edge after release.
- R2: A sender write (s_we=1) to offset 0x0 sets to 1 every flag whose s_wdata bit is 1. Bits written as 0 leave their flag unchanged.
- R3: A sender write to offset 0x4 clears every flag whose s_wdata bit is 1. Bits written as 0 leave their flag unchanged.
- R4: A receiver write (r_we=1) to offset 0x4 clears every flag whose r_wdata bit is 1. Bits written as 0 leave their flag unchanged.
- R5: When a set and an acknowledge reach the same flag on the same edge, the flag ends at 1. When they reach different flags on the same edge, both take effect.
- R6: A sender read of offset 0x8 and a receiver read of offset 0x0 both return the flag vector. The value appears on the read data the cycle after the address is sampled, and it shows the flags as they stood before that edge's writes.
- R7: Reads of sender offsets 0x0, 0x4 and 0xC, and of receiver offsets 0x4, 0x8 and 0xC, return 0.
- R8: Writes to sender offset 0x8, receiver offset 0x0, or any unmapped offset do not change any flag.
- R9: irq_o[k], for k from 0 to 3, is 1 exactly while flag k+1 is 1. Flags 5 to 32 drive no interrupt line.
- R10: With no write to a set, withdraw or acknowledge offset, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| s_addr | input | 4 | Sender byte offset |
| s_we | input | 1 | Sender write strobe |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender registered read data |
| r_addr | input | 4 | Receiver byte offset |
| r_we | input | 1 | Receiver write strobe |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver registered read data |
| irq_o | output | 4 | Level interrupt lines for flags 1 to 4 |

## Verification
A sender set and a receiver acknowledge can arrive on the same edge, because the two ports are independent. The bench provokes this on purpose in two ways: with overlapping masks, where the set must win, and with disjoint masks, where both updates must apply. A long random phase then drives both ports every cycle. A behavioural model settles each flag bit by bit with set priority, and the bench compares both read ports and the interrupt lines against that model on every clock.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;
  localparam int unsigned OFF_TX_SET    = 32'h0;
  localparam int unsigned OFF_TX_CLR    = 32'h4;
  localparam int unsigned OFF_TX_FLAG   = 32'h8;
  localparam int unsigned OFF_RX_STATUS = 32'h0;
  localparam int unsigned OFF_RX_ACK    = 32'h4;

  typedef enum logic [1:0] {TX_NONE, TX_SET, TX_CLR, TX_FLAG} tx_sel_e;
  typedef enum logic [1:0] {RX_NONE, RX_STATUS, RX_ACK} rx_sel_e;
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ipc_tx_port.sv
module ipc_tx_port
  import ipc_flag_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [NUM_FLAGS-1:0] wdata,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic [NUM_FLAGS-1:0] clr_o,
  output logic [NUM_FLAGS-1:0] rdata_o
);
  tx_sel_e              sel;
  logic [NUM_FLAGS-1:0] rdata_d;
  logic [NUM_FLAGS-1:0] rdata_q;
  logic                 rd_en;

  always_comb begin
    if (addr == ADDR_W'(OFF_TX_SET))       sel = TX_SET;
    else if (addr == ADDR_W'(OFF_TX_CLR))  sel = TX_CLR;
    else if (addr == ADDR_W'(OFF_TX_FLAG)) sel = TX_FLAG;
    else                                   sel = TX_NONE;
  end

  always_comb begin
    set_o   = (we && sel == TX_SET) ? wdata : '0;
    clr_o   = (we && sel == TX_CLR) ? wdata : '0;
    rdata_d = (sel == TX_FLAG) ? flags : '0;
    rd_en   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ipc_rx_port.sv
module ipc_rx_port
  import ipc_flag_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_FLAGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [NUM_FLAGS-1:0] wdata,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] ack_o,
  output logic [NUM_FLAGS-1:0] rdata_o
);
  rx_sel_e              sel;
  logic [NUM_FLAGS-1:0] rdata_d;
  logic [NUM_FLAGS-1:0] rdata_q;
  logic                 rd_en;

  always_comb begin
    if (addr == ADDR_W'(OFF_RX_STATUS))   sel = RX_STATUS;
    else if (addr == ADDR_W'(OFF_RX_ACK)) sel = RX_ACK;
    else                                  sel = RX_NONE;
  end

  always_comb begin
    ack_o   = (we && sel == RX_ACK) ? wdata : '0;
    rdata_d = (sel == RX_STATUS) ? flags : '0;
    rd_en   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ipc_flag_core.sv
module ipc_flag_core #(
  parameter int NUM_FLAGS = 32,
  parameter int NUM_IRQ   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  input  logic [NUM_FLAGS-1:0] ack_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_IRQ-1:0]   irq_o
);
  logic [NUM_FLAGS-1:0] flag_d;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 upd_en;

  assign upd_en = |{set_i, clr_i, ack_i};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    // set has priority so a fresh event is never dropped
    assign flag_d[i] = set_i[i] | (flag_q[i] & ~(clr_i[i] | ack_i[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= '0;
    else if (upd_en) flag_q <= flag_d;
  end

  assign flags_o = flag_q;
  assign irq_o   = flag_q[NUM_IRQ-1:0];
endmodule

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank #(
  parameter int ADDR_W    = 4,
  parameter int NUM_FLAGS = 32,
  parameter int NUM_IRQ   = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    s_addr,
  input  logic                 s_we,
  input  logic [NUM_FLAGS-1:0] s_wdata,
  output logic [NUM_FLAGS-1:0] s_rdata,
  input  logic [ADDR_W-1:0]    r_addr,
  input  logic                 r_we,
  input  logic [NUM_FLAGS-1:0] r_wdata,
  output logic [NUM_FLAGS-1:0] r_rdata,
  output logic [NUM_IRQ-1:0]   irq_o
);
  logic                 rst_sync_n;
  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] set_m;
  logic [NUM_FLAGS-1:0] clr_m;
  logic [NUM_FLAGS-1:0] ack_m;

  ipc_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sync_n)
  );

  ipc_tx_port #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .addr(s_addr), .we(s_we), .wdata(s_wdata),
    .flags(flags_q), .set_o(set_m), .clr_o(clr_m), .rdata_o(s_rdata)
  );

  ipc_rx_port #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .addr(r_addr), .we(r_we), .wdata(r_wdata),
    .flags(flags_q), .ack_o(ack_m), .rdata_o(r_rdata)
  );

  ipc_flag_core #(.NUM_FLAGS(NUM_FLAGS), .NUM_IRQ(NUM_IRQ)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .set_i(set_m), .clr_i(clr_m), .ack_i(ack_m),
    .flags_o(flags_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/ipc_flag_bank_chk.sv
module ipc_flag_bank_chk
  import ipc_flag_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_FLAGS = 32,
  parameter int NUM_IRQ   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    s_addr,
  input logic                 s_we,
  input logic [NUM_FLAGS-1:0] s_wdata,
  input logic [NUM_FLAGS-1:0] s_rdata,
  input logic [ADDR_W-1:0]    r_addr,
  input logic                 r_we,
  input logic [NUM_FLAGS-1:0] r_wdata,
  input logic [NUM_FLAGS-1:0] r_rdata,
  input logic [NUM_IRQ-1:0]   irq_o,
  input logic [NUM_FLAGS-1:0] flags
);
  logic                 wr_set, wr_clr, wr_ack;
  logic [NUM_FLAGS-1:0] set_mask;

  assign wr_set   = s_we && (s_addr == ADDR_W'(OFF_TX_SET));
  assign wr_clr   = s_we && (s_addr == ADDR_W'(OFF_TX_CLR));
  assign wr_ack   = r_we && (r_addr == ADDR_W'(OFF_RX_ACK));
  assign set_mask = wr_set ? s_wdata : '0;

  AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((flags & $past(s_wdata)) == $past(s_wdata)));  // R2
  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((flags & $past(s_wdata)) == '0));  // R3
  AST_ACK_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((flags & $past(r_wdata) & ~$past(set_mask)) == '0));  // R4
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && wr_ack) |=> ((flags & $past(s_wdata & r_wdata)) == $past(s_wdata & r_wdata)));  // R5
  AST_VIEWS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_addr == ADDR_W'(OFF_TX_FLAG) && r_addr == ADDR_W'(OFF_RX_STATUS)) |=> (s_rdata == r_rdata));  // R6
  AST_TX_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s_addr != ADDR_W'(OFF_TX_FLAG)) |=> (s_rdata == '0));  // R7
  AST_RX_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (r_addr != ADDR_W'(OFF_RX_STATUS)) |=> (r_rdata == '0));  // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr || wr_ack) |=> $stable(flags));  // R10
  AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_set |=> ((irq_o & ~$past(irq_o)) == '0));  // R9
endmodule

bind ipc_flag_bank ipc_flag_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS), .NUM_IRQ(NUM_IRQ)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata),
  .s_rdata(s_rdata), .r_addr(r_addr), .r_we(r_we), .r_wdata(r_wdata),
  .r_rdata(r_rdata), .irq_o(irq_o), .flags(flags_q)
);

// File: tb/ipc_flag_bank_tb_top.sv
`timescale 1ns/1ps
module ipc_flag_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  s_addr, r_addr;
  logic        s_we, r_we;
  logic [31:0] s_wdata, r_wdata, s_rdata, r_rdata;
  logic [3:0]  irq_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  // reference model
  logic [31:0] m_flags, m_s_rd, m_r_rd;
  int          rel_cnt;

  always #4 clk = ~clk;

  ipc_flag_bank dut_i (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .r_addr(r_addr), .r_we(r_we), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .irq_o(irq_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags <= '0; m_s_rd <= '0; m_r_rd <= '0; rel_cnt <= 0;
    end else begin
      if (rel_cnt >= 2) begin
        logic [31:0] nxt;
        nxt = m_flags;
        for (int b = 0; b < 32; b++) begin
          if (s_we && s_addr == 4'h0 && s_wdata[b]) nxt[b] = 1'b1;
          else if ((s_we && s_addr == 4'h4 && s_wdata[b]) ||
                   (r_we && r_addr == 4'h4 && r_wdata[b])) nxt[b] = 1'b0;
        end
        m_s_rd  <= (s_addr == 4'h8) ? m_flags : 32'h0;
        m_r_rd  <= (r_addr == 4'h0) ? m_flags : 32'h0;
        m_flags <= nxt;
      end
      if (rel_cnt < 3) rel_cnt <= rel_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_cmp += 3;
      if (s_rdata !== m_s_rd) begin
        n_bad++;
        $display("FAIL %s (R6 R7) s_rdata actual=%h expected=%h", cur_req, s_rdata, m_s_rd);
      end
      if (r_rdata !== m_r_rd) begin
        n_bad++;
        $display("FAIL %s (R6 R7) r_rdata actual=%h expected=%h", cur_req, r_rdata, m_r_rd);
      end
      if (irq_o !== m_flags[3:0]) begin
        n_bad++;
        $display("FAIL %s (R9) irq_o actual=%h expected=%h", cur_req, irq_o, m_flags[3:0]);
      end
    end
  end

  task automatic drv(input logic sw, input logic [3:0] sa, input logic [31:0] sd,
                     input logic rw, input logic [3:0] ra, input logic [31:0] rd);
    @(posedge clk); #2;
    s_we = sw; s_addr = sa; s_wdata = sd;
    r_we = rw; r_addr = ra; r_wdata = rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(1'b0, 4'h8, 32'h0, 1'b0, 4'h0, 32'h0);
  endtask

  task automatic run_all();
    cur_req = "R1";
    rst_n = 1'b0;
    idle(3);
    chk_on = 1'b1;
    idle(2);
    rst_n = 1'b1;
    drv(1'b1, 4'h0, 32'hFFFF_FFFF, 1'b0, 4'h0, 32'h0); // inside sync window: ignored
    idle(4);
    cur_req = "R2";
    drv(1'b1, 4'h0, 32'h0000_0005, 1'b0, 4'h0, 32'h0);
    drv(1'b1, 4'h0, 32'h8000_0010, 1'b0, 4'h0, 32'h0);
    idle(2);
    cur_req = "R6";
    drv(1'b0, 4'h8, 32'h0, 1'b0, 4'h0, 32'h0);
    idle(2);
    cur_req = "R7";
    drv(1'b0, 4'h0, 32'h0, 1'b0, 4'h4, 32'h0);
    drv(1'b0, 4'h4, 32'h0, 1'b0, 4'h8, 32'h0);
    drv(1'b0, 4'hC, 32'h0, 1'b0, 4'hC, 32'h0);
    idle(2);
    cur_req = "R8";
    drv(1'b1, 4'h8, 32'hFFFF_FFFF, 1'b1, 4'h0, 32'hFFFF_FFFF);
    drv(1'b1, 4'hC, 32'hFFFF_FFFF, 1'b1, 4'h8, 32'hFFFF_FFFF);
    drv(1'b1, 4'hC, 32'h0000_0000, 1'b1, 4'hC, 32'hFFFF_FFFF);
    idle(2);
    cur_req = "R3";
    drv(1'b1, 4'h4, 32'h0000_0001, 1'b0, 4'h0, 32'h0);
    idle(2);
    cur_req = "R4";
    drv(1'b0, 4'h8, 32'h0, 1'b1, 4'h4, 32'h8000_0000);
    drv(1'b0, 4'h8, 32'h0, 1'b1, 4'h4, 32'h0000_0000);
    idle(2);
    cur_req = "R5";
    drv(1'b1, 4'h0, 32'h0000_000F, 1'b1, 4'h4, 32'h0000_000F);
    idle(2);
    drv(1'b1, 4'h0, 32'h0000_0100, 1'b1, 4'h4, 32'h0000_0003);
    idle(2);
    cur_req = "R9";
    drv(1'b1, 4'h4, 32'h0000_0004, 1'b0, 4'h0, 32'h0);
    drv(1'b0, 4'h8, 32'h0, 1'b1, 4'h4, 32'h0000_0008);
    drv(1'b1, 4'h0, 32'hFFFF_FFF0, 1'b0, 4'h0, 32'h0);
    idle(2);
    cur_req = "R10";
    idle(6);
    cur_req = "R1";
    @(posedge clk); #2; rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      logic [3:0] sa, ra;
      sa = 4'($urandom_range(0, 3) * 4);
      ra = 4'($urandom_range(0, 3) * 4);
      drv(1'($urandom), sa, $urandom, 1'($urandom), ra, $urandom);
    end
    idle(3);
  endtask

  initial begin
    rst_n = 1'b0; s_we = 1'b0; r_we = 1'b0;
    s_addr = '0; r_addr = '0; s_wdata = '0; r_wdata = '0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule